// File: doc/BRIEF.md
# Host-Fed Speech Byte Port

This block is the slave-side entry for a speech player: a small 4-bit or 8-bit host CPU pushes coded speech bytes one at a time, instead of the player fetching them from its own ROM. Slave streaming starts when the host pulls the mode input low for a short pulse. That input rests high. After a fixed arming delay the block pulls the active-low busy output low. From then on it raises a data request whenever its single-byte holding register is empty.

The host answers each request with a write strobe while chip select is low. The request drops on the strobe's falling edge, and the byte is captured on the strobe's rising edge. The captured byte goes to the decoder through a valid/ready handshake. When the decoder takes the byte, the request is raised again on the next cycle. When the decoder signals the end of the message, the block returns to idle and busy goes high.

While the block is arming or streaming, or while the standby input is high, a mode pulse is refused. A write that arrives with no request pending is dropped and sets a sticky error. A request left unanswered too long sets a sticky late flag. All inputs are assumed to be already synchronous to the clock.

Top module: `slv_host_port`

## Requirements
- R1: After reset, req is 0, busy_n is 1, dec_valid is 0, and wr_err and late_err are both 0.
- R2: When the clock edge that samples mode_n low follows one that sampled it high, and the block is idle with standby low, busy_n reads 0 after exactly ARM_CYCLES+1 clock edges, counting that sampling edge as the first.
- R3: A falling edge on mode_n while standby is high, or while the block is arming or streaming, has no effect: busy_n and req keep their values.
- R4: On entry to streaming, req rises one cycle after busy_n falls. req is never 1 while the holding register is full.
- R5: When wr_n falls while cs_n is 0 and req is 1, req is 0 after that edge. On the following rising edge of wr_n (cs_n still 0), host_data is captured, and after that edge dec_valid is 1 and dec_data equals the byte.
- R6: Strobes made while cs_n is 1 are ignored: no capture, no request change, no error.
- R7: A falling edge of wr_n with cs_n at 0 while req is 0 captures nothing and sets wr_err. wr_err stays 1 until reset.
- R8: While dec_valid is 1 and dec_ready is 0, dec_valid stays 1 and dec_data stays stable. After the edge at which dec_valid and dec_ready are both 1, dec_valid is 0 and req is 1.
- R9: A msg_end pulse during streaming returns the block to idle after that edge: busy_n is 1, req is 0, dec_valid is 0. A later mode pulse is accepted again.
- R10: If req stays 1 for LATE_CYCLES consecutive cycles without an accepted strobe, late_err is 1 after the next edge. late_err stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_n | input | 1 | Slave-entry pulse, active low, rests high |
| standby | input | 1 | High while the player is in standby; blocks mode entry |
| cs_n | input | 1 | Chip select, active low, qualifies wr_n |
| wr_n | input | 1 | Write strobe, active low |
| host_data | input | DATA_W | Byte from the host |
| msg_end | input | 1 | One-cycle pulse from the decoder ending the message |
| req | output | 1 | Data request to the host |
| busy_n | output | 1 | Low while streaming |
| dec_valid | output | 1 | Holding register full |
| dec_ready | input | 1 | Decoder takes the byte |
| dec_data | output | DATA_W | Held byte |
| wr_err | output | 1 | Sticky: write arrived with no request pending |
| late_err | output | 1 | Sticky: request went unanswered too long |

## Verification
The bench streams every byte value through the port. Host delays and decoder back-pressure are varied, so a design that captured on the wrong strobe edge, or let the held byte change under back-pressure, would deliver wrong bytes. It counts the exact edge at which busy falls, catching an off-by-one arming counter. It sends mode pulses during standby and while streaming, which a design that restarted arming would answer with a busy pulse or a lost request. Unselected strobes, stray writes in idle, and a request left to time out check that the error flags set exactly when required and never spuriously.

// File: rtl/slv_host_pkg.sv
package slv_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARM    = 2'd1,
        ST_STREAM = 2'd2
    } slv_state_e;

endpackage

// File: rtl/slv_mode_ctl.sv
module slv_mode_ctl
    import slv_host_pkg::*;
#(
    parameter int ARM_CYCLES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_n,
    input  logic standby,
    input  logic msg_end,
    output logic streaming,
    output logic busy_n
);

    localparam int CW = $clog2(ARM_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(ARM_CYCLES - 1);

    typedef struct packed {
        slv_state_e    st;
        logic [CW-1:0] cnt;
        logic          mode_q;
    } ctl_t;

    ctl_t r_q, r_d;
    logic mode_fall;

    always_comb begin
        r_d        = r_q;
        r_d.mode_q = mode_n;
        mode_fall  = r_q.mode_q & ~mode_n;
        case (r_q.st)
            ST_IDLE: begin
                if (mode_fall && !standby) begin
                    r_d.st  = ST_ARM;
                    r_d.cnt = '0;
                end
            end
            ST_ARM: begin
                if (r_q.cnt == LAST) begin
                    r_d.st = ST_STREAM;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_STREAM: begin
                if (msg_end) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.cnt    <= '0;
            r_q.mode_q <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign streaming = (r_q.st == ST_STREAM);
    assign busy_n    = ~streaming;

    // independent watch of time spent arming
    logic [CW:0] arm_age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                arm_age_q <= '0;
        else if (r_q.st == ST_ARM) arm_age_q <= arm_age_q + 1'b1;
        else                       arm_age_q <= '0;
    end

    // R2: arming never outlasts its window
    p_arm_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_age_q <= (CW+1)'(ARM_CYCLES));

    // R3: standby blocks entry from idle
    p_standby_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && r_q.st == ST_IDLE) |=> (r_q.st == ST_IDLE));

    // R3: a pulse while streaming does not restart arming
    p_no_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (streaming && !msg_end) |=> streaming);

    // R9: end of message releases busy
    p_end_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (streaming && msg_end) |=> busy_n);

endmodule

// File: rtl/slv_wr_port.sv
module slv_wr_port #(
    parameter int DATA_W      = 8,
    parameter int LATE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] host_data,
    input  logic              streaming,
    input  logic              msg_end,
    input  logic              dec_ready,
    output logic              req,
    output logic              dec_valid,
    output logic [DATA_W-1:0] dec_data,
    output logic              wr_err,
    output logic              late_err
);

    localparam int LW = $clog2(LATE_CYCLES + 1);
    localparam logic [LW-1:0] LLAST = LW'(LATE_CYCLES - 1);

    typedef struct packed {
        logic              wr_q;
        logic              live;
        logic              req;
        logic              claim;
        logic              full;
        logic [DATA_W-1:0] hold;
        logic              werr;
        logic              lerr;
        logic [LW-1:0]     lcnt;
    } port_t;

    port_t r_q, r_d;
    logic  sel, stb_fall, stb_rise, run;

    always_comb begin
        r_d      = r_q;
        r_d.wr_q = wr_n;
        r_d.live = streaming;
        sel      = ~cs_n;
        stb_fall = sel & r_q.wr_q & ~wr_n;
        stb_rise = sel & ~r_q.wr_q & wr_n;
        run      = streaming & ~msg_end;

        if (stb_fall && !r_q.req) begin
            r_d.werr = 1'b1;
        end

        if (!run) begin
            r_d.req   = 1'b0;
            r_d.claim = 1'b0;
            r_d.full  = 1'b0;
            r_d.lcnt  = '0;
        end else begin
            if (!r_q.live) begin
                r_d.req = 1'b1;
            end
            if (stb_fall && r_q.req) begin
                r_d.req   = 1'b0;
                r_d.claim = 1'b1;
            end
            if (stb_rise && r_q.claim) begin
                r_d.hold  = host_data;
                r_d.full  = 1'b1;
                r_d.claim = 1'b0;
            end
            if (r_q.full && dec_ready) begin
                r_d.full = 1'b0;
                r_d.req  = 1'b1;
            end
            if (r_q.req && !stb_fall) begin
                if (r_q.lcnt == LLAST) begin
                    r_d.lerr = 1'b1;
                end else begin
                    r_d.lcnt = r_q.lcnt + 1'b1;
                end
            end else begin
                r_d.lcnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.wr_q  <= 1'b1;
            r_q.live  <= 1'b0;
            r_q.req   <= 1'b0;
            r_q.claim <= 1'b0;
            r_q.full  <= 1'b0;
            r_q.hold  <= '0;
            r_q.werr  <= 1'b0;
            r_q.lerr  <= 1'b0;
            r_q.lcnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req       = r_q.req;
    assign dec_valid = r_q.full;
    assign dec_data  = r_q.hold;
    assign wr_err    = r_q.werr;
    assign late_err  = r_q.lerr;

    // R4: request only with an empty holding register
    p_req_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !dec_valid);

    // R5: accepted strobe drops the request
    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && r_q.wr_q && !wr_n && req) |=> !req);

    // R8: held byte is stable under back-pressure
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready && streaming && !msg_end) |=> (dec_valid && $stable(dec_data)));

    // R7: write error is sticky
    p_werr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    // R10: late flag is sticky
    p_lerr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        late_err |=> late_err);

endmodule

// File: rtl/slv_host_port.sv
module slv_host_port #(
    parameter int DATA_W      = 8,
    parameter int ARM_CYCLES  = 12,
    parameter int LATE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_n,
    input  logic              standby,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] host_data,
    input  logic              msg_end,
    output logic              req,
    output logic              busy_n,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [DATA_W-1:0] dec_data,
    output logic              wr_err,
    output logic              late_err
);

    logic streaming;

    slv_mode_ctl #(.ARM_CYCLES(ARM_CYCLES)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_n    (mode_n),
        .standby   (standby),
        .msg_end   (msg_end),
        .streaming (streaming),
        .busy_n    (busy_n)
    );

    slv_wr_port #(.DATA_W(DATA_W), .LATE_CYCLES(LATE_CYCLES)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .host_data (host_data),
        .streaming (streaming),
        .msg_end   (msg_end),
        .dec_ready (dec_ready),
        .req       (req),
        .dec_valid (dec_valid),
        .dec_data  (dec_data),
        .wr_err    (wr_err),
        .late_err  (late_err)
    );

    // R9: nothing is requested or offered outside streaming
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_n |-> (!req && !dec_valid));

endmodule

// File: tb/slv_host_port_tb.sv
module slv_host_port_tb;

    localparam int DW   = 8;
    localparam int ARM  = 12;
    localparam int LATE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_n = 1'b1, standby = 1'b0, cs_n = 1'b1, wr_n = 1'b1;
    logic msg_end = 1'b0, dec_ready = 1'b0;
    logic [DW-1:0] host_data = '0;
    logic req, busy_n, dec_valid, wr_err, late_err;
    logic [DW-1:0] dec_data;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    slv_host_port #(.DATA_W(DW), .ARM_CYCLES(ARM), .LATE_CYCLES(LATE)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_n(mode_n), .standby(standby),
        .cs_n(cs_n), .wr_n(wr_n), .host_data(host_data), .msg_end(msg_end),
        .req(req), .busy_n(busy_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
        .dec_data(dec_data), .wr_err(wr_err), .late_err(late_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ck(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic mode_pulse();
        mode_n = 1'b0;
        tick();
        mode_n = 1'b1;
    endtask

    // accepted write: checks request drop and capture
    task automatic host_write(input logic [DW-1:0] v);
        cs_n = 1'b0; wr_n = 1'b0; host_data = v;
        tick();
        ck("R5 req after strobe fall", int'(req), 0);
        wr_n = 1'b1;
        tick();
        cs_n = 1'b1;
        ck("R5 valid after strobe rise", int'(dec_valid), 1);
        ck("R5 captured byte", int'(dec_data), int'(v));
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        ck("R1 req", int'(req), 0);
        ck("R1 busy_n", int'(busy_n), 1);
        ck("R1 dec_valid", int'(dec_valid), 0);
        ck("R1 wr_err", int'(wr_err), 0);
        ck("R1 late_err", int'(late_err), 0);

        // R3: standby refuses entry
        standby = 1'b1;
        mode_pulse();
        repeat (ARM + 3) tick();
        ck("R3 busy_n under standby", int'(busy_n), 1);
        ck("R3 req under standby", int'(req), 0);
        standby = 1'b0;
        tick();

        // R2: exact arming delay
        mode_pulse();
        repeat (ARM - 1) tick();
        ck("R2 busy_n one edge early", int'(busy_n), 1);
        tick();
        ck("R2 busy_n on time", int'(busy_n), 0);
        ck("R4 req not yet", int'(req), 0);
        tick();
        ck("R4 req on entry", int'(req), 1);

        // R3: pulse while streaming ignored
        mode_pulse();
        repeat (ARM + 2) tick();
        ck("R3 busy_n while streaming", int'(busy_n), 0);
        ck("R3 req while streaming", int'(req), 1);

        // R6: unselected strobe
        cs_n = 1'b1; host_data = 8'hA5; wr_n = 1'b0;
        tick();
        wr_n = 1'b1;
        tick();
        ck("R6 req kept", int'(req), 1);
        ck("R6 no capture", int'(dec_valid), 0);
        ck("R6 no error", int'(wr_err), 0);

        // sweep all byte values with varied timing
        for (int v = 0; v < 256; v++) begin
            repeat (v % 4) tick();
            host_write(DW'(v));
            for (int k = 0; k < v % 3; k++) begin
                tick();
                ck("R8 valid held", int'(dec_valid), 1);
                ck("R8 data held", int'(dec_data), v);
                ck("R4 no req while full", int'(req), 0);
            end
            dec_ready = 1'b1;
            tick();
            dec_ready = 1'b0;
            ck("R8 valid after take", int'(dec_valid), 0);
            ck("R8 req after take", int'(req), 1);
        end
        ck("R10 no late flag on prompt host", int'(late_err), 0);
        ck("R7 no error on clean stream", int'(wr_err), 0);

        // R10: unanswered request
        repeat (LATE - 1) tick();
        ck("R10 late one edge early", int'(late_err), 0);
        tick();
        ck("R10 late flag", int'(late_err), 1);

        // R9: end with a byte held
        host_write(8'h3C);
        msg_end = 1'b1;
        tick();
        msg_end = 1'b0;
        ck("R9 busy_n", int'(busy_n), 1);
        ck("R9 req", int'(req), 0);
        ck("R9 dec_valid", int'(dec_valid), 0);

        // R7: stray write in idle
        cs_n = 1'b0; wr_n = 1'b0; host_data = 8'h77;
        tick();
        wr_n = 1'b1;
        tick();
        cs_n = 1'b1;
        ck("R7 wr_err set", int'(wr_err), 1);
        ck("R7 no capture", int'(dec_valid), 0);
        repeat (3) tick();
        ck("R7 wr_err sticky", int'(wr_err), 1);
        ck("R10 late sticky", int'(late_err), 1);

        // R9: re-entry after end
        mode_pulse();
        repeat (ARM) tick();
        ck("R9 re-entry busy_n", int'(busy_n), 0);
        tick();
        ck("R9 re-entry req", int'(req), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule